// File: doc/BRIEF.md
# Serial Interface Clock and Counter Control

This block is the clock front end of a small general-purpose serial interface. Software programs it through one 8-bit control word. The word holds two interrupt enables, a 2-bit output wire-mode field and a 2-bit clock-source field. It also carries two write-only strobes that software uses to produce clocks by hand.

From the selected source the block makes one shift/count event per cycle, at most. The source is a software strobe, a compare-match pulse from a timer, or a chosen edge of an external clock pin after a two-flop synchronizer. Each event advances a 4-bit counter. When the counter wraps, it sets a sticky overflow flag.

The overflow flag and an externally supplied start-condition flag are each gated with their enable bits and a global interrupt enable. The results are the two interrupt request outputs. The event itself is brought out as `shift_clk` so that a neighbouring shift register can use it.

Top module: `usi_clkctl`

## Requirements
- R1: After reset, `reg_rd_data` is 0x00, `cnt_val` is 0, `ovf_flag`, `ovf_irq`, `start_irq` and `shift_clk` are 0, and `wire_mode` is 00.
- R2: A write stores bits 7..2 of `reg_wr_data` and returns them on `reg_rd_data` from the next cycle. Bits 1 and 0 always read 0. The bit map is: 7 start-interrupt enable, 6 overflow-interrupt enable, 5..4 wire mode, 3..2 clock source, 1 software-clock strobe, 0 toggle strobe.
- R3: A write whose data has clock source 00 and bit 1 set advances the counter by one at that write's clock edge. A write with bit 0 set but bit 1 clear does not advance it.
- R4: With clock source 01, each cycle of `timer_match` high advances the counter by one. In any other clock-source setting, `timer_match` has no effect.
- R5: With clock source 10, a rising edge on `ext_clk_pin` advances the counter at the third rising clock edge after the pin changes, and not earlier. A falling edge has no effect.
- R6: With clock source 11, a falling edge on `ext_clk_pin` advances the counter. A rising edge has no effect.
- R7: A write whose data has clock-source bit 3 set and both bits 1 and 0 set advances the counter by one. The same write with only bit 0 set does not.
- R8: The wire-mode field (bits 5..4) changes no counting behaviour. External pin edges count with wire mode 00 and with every other value. The field is driven on `wire_mode`.
- R9: A counter step from 15 to 0 sets `ovf_flag`, which then holds until `ovf_clr` is high for a cycle. If a wrap and `ovf_clr` fall in the same cycle, the flag is set.
- R10: The counter advances by exactly one in a cycle where any enabled source fires, even when several fire together. `shift_clk` is high in that cycle.
- R11: `ovf_irq` equals `ovf_flag` AND bit 6 AND `glob_int_en`. It rises in the cycle after the enable is written while the flag is already pending.
- R12: `start_irq` equals `start_flag` AND bit 7 AND `glob_int_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 8 | Control word write data |
| reg_rd_data | output | 8 | Control word readback, strobes read 0 |
| ext_clk_pin | input | 1 | Asynchronous external clock pin |
| timer_match | input | 1 | Timer compare-match pulse |
| start_flag | input | 1 | Start-condition flag from the line detector |
| glob_int_en | input | 1 | Global interrupt enable |
| ovf_clr | input | 1 | Clears the overflow flag (write-one-to-clear) |
| wire_mode | output | 2 | Selected output wire mode |
| shift_clk | output | 1 | One-cycle shift/count event |
| cnt_val | output | 4 | Counter value |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| start_irq | output | 1 | Start-condition interrupt request |

## Verification
Two functions can land in the same cycle. The first pair is the setting and the software clearing of the overflow flag. The bench brings the counter to 15 and drives the wrapping clock and `ovf_clr` in the same cycle, then expects a counter of 0 and a set flag. The second pair is a software strobe and a hardware clock arriving together; the bench fires a strobe write and a timer pulse in one cycle and judges that the count moves by one, not two.

// File: rtl/usi_clkctl_pkg.sv
package usi_clkctl_pkg;

  localparam int REG_W  = 8;
  localparam int CNT_W  = 4;
  localparam int SYNC_N = 2;

  typedef enum logic [1:0] {
    SRC_SOFT    = 2'b00,
    SRC_TIMER   = 2'b01,
    SRC_EXT_POS = 2'b10,
    SRC_EXT_NEG = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic     start_ie;
    logic     ovf_ie;
    logic [1:0] wire_mode;
    clk_src_e clk_src;
  } ctrl_t;

  // Stored part of a written control word (bits 7..2).
  function automatic ctrl_t ctrl_of(input logic [REG_W-1:0] d);
    return ctrl_t'(d[REG_W-1:2]);
  endfunction

  // A write produces a software clock in two ways. With the soft source,
  // the clock strobe alone is enough. With either external source, the
  // clock strobe and the toggle strobe must both be set.
  function automatic logic soft_clock_of(input logic [REG_W-1:0] d);
    logic [1:0] src;
    src = d[3:2];
    return ((src == 2'b00) && d[1]) || (src[1] && d[1] && d[0]);
  endfunction

endpackage

// File: rtl/usi_ctrl_reg.sv
module usi_ctrl_reg
  import usi_clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rd_data,
  output logic             soft_clk_evt
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_of(wr_data);
  end

  assign ctrl         = ctrl_q;
  assign rd_data      = {ctrl_q, 2'b00};
  assign soft_clk_evt = wr_en && soft_clock_of(wr_data);

  p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[REG_W-1:2] == $past(wr_data[REG_W-1:2])) && (rd_data[1:0] == 2'b00));

endmodule

// File: rtl/usi_clk_sel.sv
module usi_clk_sel
  import usi_clkctl_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_N
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin,
  input  logic     timer_match,
  input  clk_src_e clk_src,
  input  logic     soft_clk_evt,
  output logic     ext_rise,
  output logic     ext_fall,
  output logic     shift_evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s;
  logic                   hw_evt;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  assign ext_rise = pin_s && !prev_q;
  assign ext_fall = !pin_s && prev_q;

  always_comb begin
    case (clk_src)
      SRC_SOFT:    hw_evt = 1'b0;
      SRC_TIMER:   hw_evt = timer_match;
      SRC_EXT_POS: hw_evt = ext_rise;
      default:     hw_evt = ext_fall;
    endcase
  end

  assign shift_evt = hw_evt || soft_clk_evt;

  p_ext_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rise && clk_src == SRC_EXT_POS) |-> shift_evt);

  p_ext_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_fall && clk_src == SRC_EXT_NEG) |-> shift_evt);

endmodule

// File: rtl/usi_counter.sv
module usi_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          flag_clr,
  output logic [CW-1:0] cnt,
  output logic          flag,
  output logic          wrap_evt
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic          flag_q;

  function automatic logic [CW-1:0] advance(input logic [CW-1:0] c);
    return c + 1'b1;
  endfunction

  assign wrap_evt = step && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (step) cnt_q <= advance(cnt_q);
      if (wrap_evt)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  p_step_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == CW'($past(cnt_q) + 1'b1));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));

  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == TOP) |=> flag_q);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

endmodule

// File: rtl/usi_irq_gate.sv
module usi_irq_gate #(
  parameter int N = 2
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  input  logic         gie,
  output logic [N-1:0] req
);

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_req
      assign req[i] = flags[i] && enables[i] && gie;
    end
  endgenerate

endmodule

// File: rtl/usi_clkctl.sv
module usi_clkctl
  import usi_clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             ext_clk_pin,
  input  logic             timer_match,
  input  logic             start_flag,
  input  logic             glob_int_en,
  input  logic             ovf_clr,
  output logic [1:0]       wire_mode,
  output logic             shift_clk,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf_flag,
  output logic             ovf_irq,
  output logic             start_irq
);

  localparam int N_IRQ = 2;

  ctrl_t            ctrl;
  logic             soft_clk_evt;
  logic             ext_rise;
  logic             ext_fall;
  logic             shift_evt;
  logic             wrap_evt;
  logic [N_IRQ-1:0] irq_req;

  usi_ctrl_reg u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (reg_wr_en),
    .wr_data      (reg_wr_data),
    .ctrl         (ctrl),
    .rd_data      (reg_rd_data),
    .soft_clk_evt (soft_clk_evt)
  );

  usi_clk_sel #(.SYNC_STAGES(SYNC_N)) u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin          (ext_clk_pin),
    .timer_match  (timer_match),
    .clk_src      (ctrl.clk_src),
    .soft_clk_evt (soft_clk_evt),
    .ext_rise     (ext_rise),
    .ext_fall     (ext_fall),
    .shift_evt    (shift_evt)
  );

  usi_counter #(.CW(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (shift_evt),
    .flag_clr (ovf_clr),
    .cnt      (cnt_val),
    .flag     (ovf_flag),
    .wrap_evt (wrap_evt)
  );

  usi_irq_gate #(.N(N_IRQ)) u_irq (
    .flags   ({start_flag, ovf_flag}),
    .enables ({ctrl.start_ie, ctrl.ovf_ie}),
    .gie     (glob_int_en),
    .req     (irq_req)
  );

  assign ovf_irq   = irq_req[0];
  assign start_irq = irq_req[1];
  assign wire_mode = ctrl.wire_mode;
  assign shift_clk = shift_evt;

  p_irq_immediate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr && !wrap_evt && glob_int_en && reg_wr_en && reg_wr_data[6]) |=>
      (ovf_irq || !glob_int_en));

  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag && (cnt_val == '0));

endmodule

// File: tb/usi_clkctl_tb.sv
module usi_clkctl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic       ext_clk_pin = 1'b0;
  logic       timer_match = 1'b0;
  logic       start_flag = 1'b0;
  logic       glob_int_en = 1'b0;
  logic       ovf_clr = 1'b0;
  logic [1:0] wire_mode;
  logic       shift_clk;
  logic [3:0] cnt_val;
  logic       ovf_flag;
  logic       ovf_irq;
  logic       start_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int   exp_cnt = 0;
  bit   exp_ovf = 0;
  logic [7:0] cur = '0;

  always #2 clk = ~clk;

  usi_clkctl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .ext_clk_pin(ext_clk_pin), .timer_match(timer_match),
    .start_flag(start_flag), .glob_int_en(glob_int_en), .ovf_clr(ovf_clr),
    .wire_mode(wire_mode), .shift_clk(shift_clk), .cnt_val(cnt_val),
    .ovf_flag(ovf_flag), .ovf_irq(ovf_irq), .start_irq(start_irq)
  );

  // Bench view of the rules, restated from the requirements.
  function automatic bit fn_soft_hit(input logic [7:0] d);
    bit ext_src;
    ext_src = (d >> 3) & 1;
    if (d[3:2] == 2'd0) return d[1];
    return ext_src && d[1] && d[0];
  endfunction

  function automatic int fn_next(input int c);
    return (c == 15) ? 0 : c + 1;
  endfunction

  task automatic bump();
    if (exp_cnt == 15) exp_ovf = 1;
    exp_cnt = fn_next(exp_cnt);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, int'(cnt_val), exp_cnt);
    chk(req, int'(ovf_flag), int'(exp_ovf));
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    cur = d;
    if (fn_soft_hit(d)) bump();
  endtask

  task automatic tpulse();
    @(negedge clk);
    timer_match = 1'b1;
    @(negedge clk);
    timer_match = 1'b0;
    if (cur[3:2] == 2'b01) bump();
  endtask

  task automatic toggle_pin();
    bit rising;
    @(negedge clk);
    ext_clk_pin = ~ext_clk_pin;
    rising = ext_clk_pin;
    repeat (3) @(negedge clk);
    if ((rising && cur[3:2] == 2'b10) || (!rising && cur[3:2] == 2'b11)) bump();
  endtask

  task automatic clr();
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    exp_ovf = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rd", int'(reg_rd_data), 0);
    chk("R1 cnt", int'(cnt_val), 0);
    chk("R1 ovf", int'(ovf_flag), 0);
    chk("R1 irq", int'({ovf_irq, start_irq, shift_clk}), 0);
    chk("R1 wm", int'(wire_mode), 0);

    // R2 readback and R7 external-source software clock
    wr(8'hFF);
    chk("R2 rd FF", int'(reg_rd_data), 8'hFC);
    chk_state("R7 strobe pair");
    wr(8'hA8);
    chk("R2 rd A8", int'(reg_rd_data), 8'hA8);
    chk_state("R7 no strobe");
    wr(8'h0D);
    chk("R2 rd 0D", int'(reg_rd_data), 8'h0C);
    chk_state("R7 toggle only");

    // R3 soft source
    wr(8'h02);
    chk_state("R3 soft strobe");
    wr(8'h01);
    chk_state("R3 toggle ignored");

    // R4 timer source
    wr(8'h04);
    tpulse();
    chk_state("R4 timer counts");
    wr(8'h00);
    tpulse();
    chk_state("R4 timer ignored");

    // R5 rising edge with wire mode 00 (R8), latency
    wr(8'h08);
    @(negedge clk);
    ext_clk_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 not yet", int'(cnt_val), exp_cnt);
    @(negedge clk);
    bump();
    chk_state("R5 rise counts");
    toggle_pin();
    chk_state("R5 fall ignored");

    // R6 falling edge
    wr(8'h0C);
    toggle_pin();
    chk_state("R6 rise ignored");
    toggle_pin();
    chk_state("R6 fall counts");

    // R8 other wire modes
    wr(8'h38);
    chk("R8 wm out", int'(wire_mode), 3);
    toggle_pin();
    toggle_pin();
    chk_state("R8 wm11 counts");
    wr(8'h18);
    toggle_pin();
    toggle_pin();
    chk_state("R8 wm01 counts");

    // R10 coincident soft strobe and timer pulse
    wr(8'h04);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = 8'h02;
    timer_match = 1'b1;
    #1;
    chk("R10 shift_clk", int'(shift_clk), 1);
    @(negedge clk);
    reg_wr_en = 1'b0;
    timer_match = 1'b0;
    cur = 8'h02;
    bump();
    chk_state("R10 single step");

    // R9 wrap, and wrap meeting clear
    while (exp_cnt != 15) wr(8'h02);
    wr(8'h02);
    chk_state("R9 wrap sets");
    clr();
    chk_state("R9 clear");
    while (exp_cnt != 15) wr(8'h02);
    wr(8'h04);
    @(negedge clk);
    timer_match = 1'b1;
    ovf_clr = 1'b1;
    @(negedge clk);
    timer_match = 1'b0;
    ovf_clr = 1'b0;
    bump();
    chk_state("R9 set wins");

    // R11 pending flag, enable written later
    glob_int_en = 1'b1;
    wr(8'h04);
    chk("R11 disabled", int'(ovf_irq), 0);
    wr(8'h44);
    chk("R11 immediate", int'(ovf_irq), 1);
    @(negedge clk);
    glob_int_en = 1'b0;
    #1;
    chk("R11 global off", int'(ovf_irq), 0);

    // R12 start request
    start_flag = 1'b1;
    glob_int_en = 1'b1;
    wr(8'h84);
    chk("R12 start on", int'(start_irq), 1);
    wr(8'h04);
    chk("R12 start off", int'(start_irq), 0);
    start_flag = 1'b0;

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [7:0] d;
      int act;
      d = 8'($urandom);
      wr(d);
      chk("R2 rand rd", int'(reg_rd_data), int'({d[7:2], 2'b00}));
      act = int'($urandom % 5);
      case (act)
        0: tpulse();
        1: toggle_pin();
        2: wr(d);
        3: clr();
        default: @(negedge clk);
      endcase
      @(negedge clk);
      glob_int_en = 1'($urandom);
      start_flag = 1'($urandom);
      #1;
      chk_state("R10 rand");
      chk("R11 rand", int'(ovf_irq), int'(exp_ovf && cur[6] && glob_int_en));
      chk("R12 rand", int'(start_irq), int'(start_flag && cur[7] && glob_int_en));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule